// File: doc/BRIEF.md
# Address-Decoded NAND Flash Bus Bridge

This block sits on a simple request/acknowledge processor bus and lets software operate a raw 8-bit NAND flash with nothing more than byte loads and stores. The lower half of the bus address space is a window onto the flash. Address bits of each window access pick the flash control lines for that access: command latch, address latch, chip select, spare-area select and write protect. Commands, addresses and data therefore all travel through the same data port. The upper half of the address space holds a control register and a wait/status register.

Each window access runs a strobe sequence with three phases. The strobe phase is active for a programmable number of wait cycles. The hold phase keeps the control lines and write data on the pins. The recovery phase releases everything. Every phase length is a base cycle count multiplied by a clock multiplier. Window writes are acknowledged as soon as they are accepted. Software then polls a sticky completion flag in the status register, which reads 1 only once recovery has ended. A window read stalls the bus until the data has been sampled. The flash ready pins pass through a synchroniser before software can read them.

Top module: `flashbus_bridge`

## Requirements
- R1: After reset, RE# and WE# are high, the data output enable is low, the command and address latch outputs are low, every chip-select output is at its deasserted level, the control register reads 0, and the status register reads with bit 3 (complete) set.
- R2: For a window access (bus address bit 7 = 0), address bit 2 drives the address latch, bit 3 drives the command latch, bit 4 drives chip select, bit 5 drives spare select and bit 6 drives write protect. Each line is driven for the whole strobe and hold phases of that access.
- R3: A window write holds WE# low for exactly WAIT_WR_CYC*CLK_MULT cycles (8 by default). It drives the write byte with the output enable high through the strobe and hold phases, (WAIT_WR_CYC+HOLD_CYC)*CLK_MULT cycles (12), and RE# never falls.
- R4: A window read holds RE# low for WAIT_RD_CYC*CLK_MULT cycles and never enables the data output. It returns the flash data present in the last strobe cycle on bus_rdata[7:0], with zeros above. The acknowledge is withheld until that data is sampled.
- R5: The complete flag (status bit 3) clears on the clock edge that accepts a window access. It sets on the edge that ends recovery, (WAIT+HOLD+RECOV)*CLK_MULT edges later (16 by default for a write).
- R6: Strobes run only while control bit 0 (flash mode) and bit 20 (chip enable) are both 1. Otherwise a window access is acknowledged on the next edge with no strobe, reads return 0, and the complete flag is unchanged.
- R7: Control bits 4, 5 and 6 set the polarity of chip select, spare select and write protect. A 0 makes the line active high (idle 0), and a 1 makes it active low (idle 1).
- R8: Status bit 0 is the selected ready pin after the synchroniser, taken as-is when control bit 7 is 1 and inverted when it is 0. Control bit 8 selects ready line 1 instead of line 0.
- R9: Control bit 10 routes the chip-select output to line 1. The unselected line stays at its deasserted level.
- R10: With control bit 1 clear, chip select is asserted for the strobe and hold phases (12 cycles for a write). With bit 1 set, it also stays asserted through recovery (16 cycles).
- R11: A window access that arrives while a previous one is still in progress is stalled, and is accepted on the first edge after recovery ends. Register accesses are served at all times with a one-cycle acknowledge pulse.
- R12: The control register stores only bits 0, 1, 4, 5, 6, 7, 8, 10 and 20. Every other bit reads 0. The register is at address 0x80 and the status register at 0x84.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; top bit selects registers |
| bus_wdata | input | 32 | Write data (window uses bits 7:0) |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_cs | output | CS_LINES | Chip-select lines, polarity per control |
| nand_se | output | 1 | Spare-area select |
| nand_wp | output | 1 | Write protect |
| nand_dq_o | output | 8 | Data to flash |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_i | input | 8 | Data from flash |
| nand_rdy | input | CS_LINES | Flash ready/busy pins |

## Verification
A phase counter that is off by one shows at the pins on the very access that goes wrong: the strobe, output-enable or chip-select low time is longer or shorter than specified. A completion flag that is set early or late shows up in a status read made one edge before or one edge after the end of recovery. If the sampling point of a read is wrong, the returned byte differs, because the bench changes the flash data on every strobe cycle. A wrong stall or abort in the sequencer shows up as a shifted acknowledge for back-to-back accesses, or as a strobe appearing while the block is disabled.

// File: rtl/flashbus_pkg.sv
package flashbus_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_STROBE = 2'd1,
      PH_HOLD   = 2'd2,
      PH_RECOV  = 2'd3
   } phase_e;

   // control register bit positions
   localparam int CTL_MODE   = 0;
   localparam int CTL_CSMUX  = 1;
   localparam int CTL_CSPOL  = 4;
   localparam int CTL_SEPOL  = 5;
   localparam int CTL_WPPOL  = 6;
   localparam int CTL_RDYPOL = 7;
   localparam int CTL_INSEL  = 8;
   localparam int CTL_OUTSEL = 10;
   localparam int CTL_CHIPEN = 20;

   localparam logic [31:0] CTL_MASK = (32'd1 << CTL_MODE)  | (32'd1 << CTL_CSMUX)
                                    | (32'd1 << CTL_CSPOL) | (32'd1 << CTL_SEPOL)
                                    | (32'd1 << CTL_WPPOL) | (32'd1 << CTL_RDYPOL)
                                    | (32'd1 << CTL_INSEL) | (32'd1 << CTL_OUTSEL)
                                    | (32'd1 << CTL_CHIPEN);

   // window address bits that pick flash control lines
   localparam int WA_ALE = 2;
   localparam int WA_CLE = 3;
   localparam int WA_CS  = 4;
   localparam int WA_SE  = 5;
   localparam int WA_WP  = 6;

   // status bit positions
   localparam int ST_RDY  = 0;
   localparam int ST_DONE = 3;

   typedef struct packed {
      logic ale;
      logic cle;
      logic cs;
      logic se;
      logic wp;
   } lines_t;

endpackage

// File: rtl/flashbus_rdy_sync.sv
module flashbus_rdy_sync #(
   parameter int LINES  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] rdy_raw,
   output logic [LINES-1:0] rdy_sync
);

   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("flashbus_rdy_sync: STAGES must be 2..4");
   end
   if (LINES < 1) begin : g_bad_lines
      $error("flashbus_rdy_sync: LINES must be at least 1");
   end

   localparam int WARM_W = $clog2(STAGES + 1);

   for (genvar ln = 0; ln < LINES; ln++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], rdy_raw[ln]};
      end
      assign rdy_sync[ln] = chain[STAGES-1];
   end

   logic [WARM_W-1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        warm <= '0;
      else if (warm != WARM_W'(STAGES))  warm <= warm + 1'b1;
   end

   assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == WARM_W'(STAGES)) |-> (rdy_sync == $past(rdy_raw, STAGES)));

endmodule

// File: rtl/flashbus_regs.sv
module flashbus_regs
   import flashbus_pkg::*;
#(
   parameter int CS_LINES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctl_we,
   input  logic [31:0]         ctl_wdata,
   input  logic [CS_LINES-1:0] rdy_sync,
   input  logic                done,
   output logic [31:0]         ctrl,
   output logic [31:0]         status
);

   logic rdy_sel;
   logic rdy_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl <= '0;
      else if (ctl_we) ctrl <= ctl_wdata & CTL_MASK;
   end

   assign rdy_sel = ctrl[CTL_INSEL] ? rdy_sync[1] : rdy_sync[0];
   assign rdy_bit = ctrl[CTL_RDYPOL] ? rdy_sel : ~rdy_sel;

   always_comb begin
      status          = '0;
      status[ST_RDY]  = rdy_bit;
      status[ST_DONE] = done;
   end

   assert_ctrl_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl & ~CTL_MASK) == 32'd0);

endmodule

// File: rtl/flashbus_strobe_fsm.sv
module flashbus_strobe_fsm
   import flashbus_pkg::*;
#(
   parameter int WAIT_WR_CYC = 2,
   parameter int WAIT_RD_CYC = 2,
   parameter int HOLD_CYC    = 1,
   parameter int RECOV_CYC   = 1,
   parameter int CLK_MULT    = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       start,
   input  logic       start_we,
   input  lines_t     start_lines,
   input  logic [7:0] start_wdata,
   input  logic [7:0] dq_in,
   output phase_e     phase,
   output logic       busy,
   output logic       done,
   output logic       is_write,
   output lines_t     lines,
   output logic [7:0] wdata,
   output logic       rd_valid,
   output logic [7:0] rd_data
);

   if (WAIT_WR_CYC < 1 || WAIT_RD_CYC < 1) begin : g_bad_wait
      $error("flashbus_strobe_fsm: wait counts must be at least 1");
   end
   if (HOLD_CYC < 1 || RECOV_CYC < 1) begin : g_bad_hold
      $error("flashbus_strobe_fsm: hold and recovery counts must be at least 1");
   end
   if (CLK_MULT < 1) begin : g_bad_mult
      $error("flashbus_strobe_fsm: CLK_MULT must be at least 1");
   end

   localparam int WR_T   = WAIT_WR_CYC * CLK_MULT;
   localparam int RD_T   = WAIT_RD_CYC * CLK_MULT;
   localparam int HOLD_T = HOLD_CYC * CLK_MULT;
   localparam int REC_T  = RECOV_CYC * CLK_MULT;
   localparam int MAX_A  = (WR_T > RD_T) ? WR_T : RD_T;
   localparam int MAX_B  = (HOLD_T > REC_T) ? HOLD_T : REC_T;
   localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W  = $clog2(MAX_T + 1);

   logic [CNT_W-1:0] cnt;
   logic             last;

   assign last = (cnt == '0);
   assign busy = (phase != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt      <= '0;
         done     <= 1'b1;
         is_write <= 1'b0;
         lines    <= '0;
         wdata    <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         if (!enable && phase != PH_IDLE) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
         end else begin
            unique case (phase)
               PH_IDLE: begin
                  if (start) begin
                     phase    <= PH_STROBE;
                     cnt      <= start_we ? CNT_W'(WR_T - 1) : CNT_W'(RD_T - 1);
                     done     <= 1'b0;
                     is_write <= start_we;
                     lines    <= start_lines;
                     wdata    <= start_wdata;
                  end
               end
               PH_STROBE: begin
                  if (last) begin
                     phase <= PH_HOLD;
                     cnt   <= CNT_W'(HOLD_T - 1);
                     if (!is_write) begin
                        rd_data  <= dq_in;
                        rd_valid <= 1'b1;
                     end
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               PH_HOLD: begin
                  if (last) begin
                     phase <= PH_RECOV;
                     cnt   <= CNT_W'(REC_T - 1);
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               PH_RECOV: begin
                  if (last) begin
                     phase <= PH_IDLE;
                     done  <= 1'b1;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   assert_busy_not_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   assert_start_clears_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && enable) |=> !done);

   assert_rd_sample_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (phase == PH_HOLD && !is_write));

endmodule

// File: rtl/flashbus_bridge.sv
module flashbus_bridge
   import flashbus_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int CS_LINES    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int WAIT_WR_CYC = 2,
   parameter int WAIT_RD_CYC = 2,
   parameter int HOLD_CYC    = 1,
   parameter int RECOV_CYC   = 1,
   parameter int CLK_MULT    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_req,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic                bus_ack,
   output logic [31:0]         bus_rdata,
   output logic                nand_cle,
   output logic                nand_ale,
   output logic                nand_re_n,
   output logic                nand_we_n,
   output logic [CS_LINES-1:0] nand_cs,
   output logic                nand_se,
   output logic                nand_wp,
   output logic [7:0]          nand_dq_o,
   output logic                nand_dq_oe,
   input  logic [7:0]          nand_dq_i,
   input  logic [CS_LINES-1:0] nand_rdy
);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("flashbus_bridge: ADDR_W must be at least 8");
   end
   if (CS_LINES < 2) begin : g_bad_cs
      $error("flashbus_bridge: CS_LINES must be at least 2");
   end

   localparam int REG_SEL_BIT = ADDR_W - 1;
   localparam int REG_IDX_BIT = 2;

   logic [CS_LINES-1:0] rdy_sync;
   logic [31:0]         ctrl;
   logic [31:0]         status;
   logic                fsm_done;
   logic                fsm_busy;
   logic                fsm_wr;
   logic                rd_valid;
   logic [7:0]          rd_data;
   logic [7:0]          fsm_wdata;
   lines_t              fsm_lines;
   lines_t              req_lines;
   phase_e              phase;

   logic ack_q;
   logic [31:0] rdata_q;
   logic en;
   logic is_reg;
   logic can_take;
   logic reg_hit;
   logic win_off;
   logic win_start;
   logic ctl_we;

   // ---------------- bus decode ----------------
   assign en        = ctrl[CTL_MODE] & ctrl[CTL_CHIPEN];
   assign is_reg    = bus_addr[REG_SEL_BIT];
   assign can_take  = bus_req & ~ack_q;
   assign reg_hit   = can_take & is_reg;
   assign win_off   = can_take & ~is_reg & ~en;
   assign win_start = can_take & ~is_reg & en & ~fsm_busy;
   assign ctl_we    = reg_hit & bus_we & ~bus_addr[REG_IDX_BIT];

   assign req_lines.ale = bus_addr[WA_ALE];
   assign req_lines.cle = bus_addr[WA_CLE];
   assign req_lines.cs  = bus_addr[WA_CS];
   assign req_lines.se  = bus_addr[WA_SE];
   assign req_lines.wp  = bus_addr[WA_WP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q <= reg_hit | win_off | (win_start & bus_we) | rd_valid;
         if (reg_hit && !bus_we)
            rdata_q <= bus_addr[REG_IDX_BIT] ? status : ctrl;
         else if (win_off && !bus_we)
            rdata_q <= '0;
         else if (rd_valid)
            rdata_q <= {24'd0, rd_data};
      end
   end

   assign bus_ack   = ack_q;
   assign bus_rdata = rdata_q;

   // ---------------- sub-blocks ----------------
   flashbus_rdy_sync #(
      .LINES  (CS_LINES),
      .STAGES (SYNC_STAGES)
   ) i_rdy_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .rdy_raw  (nand_rdy),
      .rdy_sync (rdy_sync)
   );

   flashbus_regs #(
      .CS_LINES (CS_LINES)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .ctl_wdata (bus_wdata),
      .rdy_sync  (rdy_sync),
      .done      (fsm_done),
      .ctrl      (ctrl),
      .status    (status)
   );

   flashbus_strobe_fsm #(
      .WAIT_WR_CYC (WAIT_WR_CYC),
      .WAIT_RD_CYC (WAIT_RD_CYC),
      .HOLD_CYC    (HOLD_CYC),
      .RECOV_CYC   (RECOV_CYC),
      .CLK_MULT    (CLK_MULT)
   ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (en),
      .start       (win_start),
      .start_we    (bus_we),
      .start_lines (req_lines),
      .start_wdata (bus_wdata[7:0]),
      .dq_in       (nand_dq_i),
      .phase       (phase),
      .busy        (fsm_busy),
      .done        (fsm_done),
      .is_write    (fsm_wr),
      .lines       (fsm_lines),
      .wdata       (fsm_wdata),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data)
   );

   // ---------------- pin drive ----------------
   logic line_on;
   logic cs_on;

   assign line_on = (phase == PH_STROBE) || (phase == PH_HOLD);
   assign cs_on   = fsm_lines.cs &
                    (line_on || (ctrl[CTL_CSMUX] && phase == PH_RECOV));

   assign nand_ale   = line_on & fsm_lines.ale;
   assign nand_cle   = line_on & fsm_lines.cle;
   assign nand_se    = (line_on & fsm_lines.se) ^ ctrl[CTL_SEPOL];
   assign nand_wp    = (line_on & fsm_lines.wp) ^ ctrl[CTL_WPPOL];
   assign nand_re_n  = ~((phase == PH_STROBE) & ~fsm_wr);
   assign nand_we_n  = ~((phase == PH_STROBE) &  fsm_wr);
   assign nand_dq_oe = fsm_wr & line_on;
   assign nand_dq_o  = fsm_wdata;

   for (genvar ln = 0; ln < CS_LINES; ln++) begin : g_cs
      localparam int OUT_LINE = (ln == 1) ? 1 : 0;
      if (ln < 2) begin : g_routed
         assign nand_cs[ln] = (cs_on & (ctrl[CTL_OUTSEL] == OUT_LINE[0])) ^ ctrl[CTL_CSPOL];
      end else begin : g_spare
         assign nand_cs[ln] = ctrl[CTL_CSPOL];
      end
   end

   assert_excl_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_re_n && !nand_we_n));

   assert_no_drive_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_dq_oe);

   assert_off_goes_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (phase == PH_IDLE));

   assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |=> !bus_ack);

endmodule

// File: tb/test_flashbus_bridge.sv
module test_flashbus_bridge;

   localparam int W  = 8;
   localparam int H  = 4;
   localparam int RC = 4;
   localparam int T  = W + H + RC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ack;
   logic [31:0] bus_rdata;
   logic        nand_cle, nand_ale, nand_re_n, nand_we_n, nand_se, nand_wp, nand_dq_oe;
   logic [1:0]  nand_cs;
   logic [7:0]  nand_dq_o;
   logic [7:0]  nand_dq_i = '0;
   logic [1:0]  nand_rdy = 2'b00;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int wtot = 0, rtot = 0, oetot = 0, cstot = 0, rrun = 0;
   logic [31:0] tb_ctrl = '0;
   logic [7:0]  rd_base = 8'hA0;
   logic [13:0] snap = '0;

   always #4 clk = ~clk;

   flashbus_bridge i_flashbus_bridge (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
      .bus_rdata(bus_rdata), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_re_n(nand_re_n), .nand_we_n(nand_we_n), .nand_cs(nand_cs),
      .nand_se(nand_se), .nand_wp(nand_wp), .nand_dq_o(nand_dq_o),
      .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rdy(nand_rdy)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // pin monitor and flash data model
   always @(negedge clk) begin
      if (!nand_re_n) rrun = rrun + 1; else rrun = 0;
      nand_dq_i = rd_base + 8'(rrun);
      if (!nand_we_n) wtot++;
      if (!nand_re_n) rtot++;
      if (nand_dq_oe) oetot++;
      if (nand_cs[tb_ctrl[10]] == ~tb_ctrl[4]) cstot++;
      if (!nand_we_n || !nand_re_n)
         snap = {nand_ale, nand_cle, nand_se, nand_wp, nand_cs, nand_dq_o};
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic we, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] r);
      bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
      do @(negedge clk); while (!bus_ack);
      r = bus_rdata;
      bus_req = 1'b0;
   endtask

   task automatic set_ctrl(input logic [31:0] v);
      logic [31:0] dummy;
      xfer(1'b1, 8'h80, v, dummy);
      tb_ctrl = v & 32'h001005F3;
   endtask

   task automatic poll_done();
      logic [31:0] s;
      do xfer(1'b0, 8'h84, 0, s); while (!s[3]);
   endtask

   function automatic logic [31:0] exp_status(input logic [31:0] c, input logic [1:0] rdy,
                                              input logic dn);
      logic sel;
      sel = c[8] ? rdy[1] : rdy[0];
      return {28'd0, dn, 2'b00, c[7] ? sel : ~sel};
   endfunction

   function automatic logic [5:0] exp_pins(input logic [31:0] c, input logic [7:0] a);
      logic [1:0] cs;
      cs[0] = ((a[4] && !c[10]) ? 1'b1 : 1'b0) ^ c[4];
      cs[1] = ((a[4] &&  c[10]) ? 1'b1 : 1'b0) ^ c[4];
      return {a[2], a[3], a[5] ^ c[5], a[6] ^ c[6], cs};
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] r;
      int c0, c1, w0, r0, o0, s0;
      void'($urandom(32'h1D2C));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 strobes", {30'd0, nand_re_n, nand_we_n}, 32'd3);
      chk("R1 lines", {27'd0, nand_dq_oe, nand_cle, nand_ale, nand_cs}, 32'd0);
      xfer(1'b0, 8'h80, 0, r); chk("R1 ctrl", r, 32'd0);
      xfer(1'b0, 8'h84, 0, r); chk("R1 status", r, exp_status(0, nand_rdy, 1'b1));

      // R12 mask
      set_ctrl(32'hFFFF_FFFF);
      xfer(1'b0, 8'h80, 0, r); chk("R12 ctrl mask", r, 32'h001005F3);

      // R6 disabled: only one of the two enable bits
      set_ctrl(32'h0000_0001);
      w0 = wtot;
      xfer(1'b1, 8'h18, 32'h70, r);
      repeat (4) @(negedge clk);
      chk("R6 no strobe mode-only", wtot - w0, 0);
      set_ctrl(32'h0010_0000);
      r0 = rtot;
      xfer(1'b0, 8'h10, 0, r);
      chk("R6 read data off", r, 0);
      chk("R6 no read strobe", rtot - r0, 0);
      xfer(1'b0, 8'h84, 0, r); chk("R6 done unchanged", r[3], 1);

      // R8 ready synchroniser, polarity and line select
      nand_rdy = 2'b01;
      set_ctrl(32'h0010_0081);
      repeat (3) @(negedge clk);
      xfer(1'b0, 8'h84, 0, r); chk("R8 line0 true", r, exp_status(tb_ctrl, nand_rdy, 1'b1));
      set_ctrl(32'h0010_0181);
      repeat (3) @(negedge clk);
      xfer(1'b0, 8'h84, 0, r); chk("R8 line1 select", r[0], 0);
      set_ctrl(32'h0010_0101);
      repeat (3) @(negedge clk);
      xfer(1'b0, 8'h84, 0, r); chk("R8 inverted", r[0], 1);

      // R5 complete flag timing around end of recovery
      set_ctrl(32'h0010_0001);
      xfer(1'b1, 8'h18, 32'h90, r);
      c0 = cyc;
      while (cyc < c0 + T - 1) @(negedge clk);
      xfer(1'b0, 8'h84, 0, r); chk("R5 flag still clear", r[3], 0);
      xfer(1'b0, 8'h84, 0, r); chk("R5 flag set after recovery", r[3], 1);

      // R11 back-to-back window writes stall
      xfer(1'b1, 8'h14, 32'h11, r);
      c0 = cyc;
      xfer(1'b1, 8'h10, 32'h22, r);
      c1 = cyc;
      chk("R11 second accept after recovery", c1 - c0, T + 1);
      poll_done();

      // R10 / R9 directed chip-select widths
      set_ctrl(32'h0010_0003);
      s0 = cstot;
      xfer(1'b1, 8'h10, 32'h33, r); poll_done();
      chk("R10 cs through recovery", cstot - s0, T);
      set_ctrl(32'h0010_0401);
      s0 = cstot;
      xfer(1'b1, 8'h10, 32'h44, r); poll_done();
      chk("R10 cs strobe+hold only", cstot - s0, W + H);
      chk("R9 cs on line 1", {30'd0, snap[9:8]}, 32'd2);

      // random accesses: R2 R3 R4 R7 R9 R10
      for (int it = 0; it < 24; it++) begin
         logic [31:0] c;
         logic [7:0]  a, d;
         logic        we;
         c  = 32'h0010_0001 | ($urandom & 32'h5F2);
         a  = {1'b0, 5'($urandom), 2'b00};
         if (it % 4 != 3) a[4] = 1'b1;
         d  = 8'($urandom);
         we = 1'($urandom);
         set_ctrl(c);
         rd_base = 8'($urandom);
         w0 = wtot; r0 = rtot; o0 = oetot; s0 = cstot;
         xfer(we, a, {24'd0, d}, r);
         if (!we) chk("R4 read data at end of strobe", r, {24'd0, rd_base + 8'(W)});
         poll_done();
         chk("R2 R7 R9 pins", {26'd0, snap[13:8]}, {26'd0, exp_pins(tb_ctrl, a)});
         if (we) begin
            chk("R3 WE# width", wtot - w0, W);
            chk("R3 data on pins", {24'd0, snap[7:0]}, {24'd0, d});
            chk("R3 oe width", oetot - o0, W + H);
            chk("R3 no RE#", rtot - r0, 0);
         end else begin
            chk("R4 RE# width", rtot - r0, W);
            chk("R4 no drive", oetot - o0, 0);
         end
         chk("R10 cs width", cstot - s0,
             a[4] ? (tb_ctrl[1] ? (we ? T : W + H + RC) : W + H) : 0);
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule